// File: doc/BRIEF.md
# Dual-Frequency Switching Cycle Timer

This block produces the switching cycle for the primary side of a flyback power converter. It runs from a fixed system clock and takes already-digitised comparator flags. It decides when each switching pulse starts and when it ends, and drives a gate-enable level together with timing strobes for the sampling logic around it. Analog comparison, slope compensation and the gate driver sit outside it.

The nominal period comes from one of two values. The long period is used on a high line and the short period on a low line. Two line-current flags choose between them, and a band between the flags keeps the last choice. A triangular hop, stepped on a fixed time base, sweeps the period around its nominal value, with a larger depth on the long period. A pulse ends at the earliest of these events: the voltage-loop trip, the current-loop trip, the current-limit trip once blanking is over, and the duty ceiling. A minimum on time protects the loop trips against early termination. Two feedback flags form a hysteretic gate that stops and restarts whole cycles in light-load bursts.

Top module: `pwm_cycle_timer`

## Requirements
- R1: After reset the gate is low, no strobe is active, the low-line range is selected, and the first turn-on comes exactly FAST_PER ticks after reset is released.
- R2: With no trip, a pulse lasts floor(P*DUTY_NUM/2^DUTY_SHIFT) ticks, where P is the period of that cycle (about 68.5 %).
- R3: A voltage-loop or current-loop trip first seen in high tick k ends the pulse after max(k, MIN_ON_TICKS) ticks. A loop trip never ends a pulse earlier than MIN_ON_TICKS.
- R4: The current-limit trip has no effect during the first BLANK_TICKS high ticks. After them it ends the pulse at once, so a trip held from tick k gives a pulse of max(k, BLANK_TICKS+1) ticks.
- R5: The line flags are sampled only while the gate is high. line_hi_i selects the long period SLOW_PER and line_lo_i selects the short period FAST_PER (line_hi_i wins when both are set). With neither set the last choice is kept. A new choice applies from the next cycle boundary, and the cycle already under way keeps its period.
- R6: fb_low_i stops new pulses from the next cycle boundary and does not shorten the pulse under way. fb_high_i (which wins over fb_low_i) restarts switching at the next cycle boundary.
- R7: The period equals base + (pos - HOP_STEPS)*step, where base and step are those of the selected range. pos runs a triangle 0..2*HOP_STEPS, starts at HOP_STEPS going up, and moves one step every HOP_DWELL ticks, so both extremes of the sweep are reached.
- R8: cycle_start_o is a one-tick pulse in the first high tick. mid_on_o is a one-tick pulse in the first low tick after a pulse, with ton_half_o = floor(pulse length / 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vloop_trip_i | input | 1 | Voltage-loop comparator tripped |
| iloop_trip_i | input | 1 | Current-loop (constant-current) comparator tripped |
| ilim_trip_i | input | 1 | Cycle-by-cycle current-limit comparator tripped |
| fb_high_i | input | 1 | Feedback above the burst restart threshold |
| fb_low_i | input | 1 | Feedback below the burst stop threshold |
| line_hi_i | input | 1 | Line current above the upper threshold |
| line_lo_i | input | 1 | Line current below the lower threshold |
| gate_o | output | 1 | Gate enable |
| cycle_start_o | output | 1 | One-tick pulse at each turn-on |
| mid_on_o | output | 1 | One-tick strobe after turn-off that carries the half on time |
| ton_half_o | output | CNT_W | Half of the last pulse length in ticks |

## Verification
The bench builds the block with FAST_PER=40, SLOW_PER=64, FAST_STEP=1, SLOW_STEP=3, HOP_STEPS=3, HOP_DWELL=100, BLANK_TICKS=3 and MIN_ON_TICKS=6. With these values a full hop triangle takes 1200 ticks, so many complete sweeps in both ranges fit in a short run, and every hop dwell is longer than the longest period, so each extreme period is certain to land on a cycle boundary. The short blanking and minimum-on windows let the bench sweep the trip tick across every position from the first high tick up past both windows, and compare each pulse length with an arithmetic duty ceiling computed from the period measured for that cycle.

// File: rtl/pwm_ct_pkg.sv
package pwm_ct_pkg;
    typedef enum logic {
        HOP_UP   = 1'b0,
        HOP_DOWN = 1'b1
    } hop_dir_e;

    typedef enum logic {
        RNG_LOW_LINE  = 1'b0,
        RNG_HIGH_LINE = 1'b1
    } line_range_e;
endpackage

// File: rtl/pwm_ct_hop.sv
module pwm_ct_hop
    import pwm_ct_pkg::*;
#(
    parameter int HOP_STEPS = 10,
    parameter int HOP_DWELL = 6350,
    localparam int POS_W = $clog2(2 * HOP_STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos_o
);
    localparam int DW = $clog2(HOP_DWELL);
    localparam logic [DW-1:0]    DWELL_LAST = DW'(HOP_DWELL - 1);
    localparam logic [POS_W-1:0] POS_MID    = POS_W'(HOP_STEPS);
    localparam logic [POS_W-1:0] POS_PEN    = POS_W'(2 * HOP_STEPS - 1);
    localparam logic [POS_W-1:0] POS_ONE    = POS_W'(1);

    typedef struct packed {
        logic [DW-1:0]    tick;
        logic [POS_W-1:0] pos;
        hop_dir_e         dir;
    } hop_t;

    hop_t hop_d, hop_q;

    always_comb begin
        hop_d = hop_q;
        if (hop_q.tick == DWELL_LAST) begin
            hop_d.tick = '0;
            if (hop_q.dir == HOP_UP) begin
                hop_d.pos = hop_q.pos + 1'b1;
                if (hop_q.pos == POS_PEN) hop_d.dir = HOP_DOWN;
            end else begin
                hop_d.pos = hop_q.pos - 1'b1;
                if (hop_q.pos == POS_ONE) hop_d.dir = HOP_UP;
            end
        end else begin
            hop_d.tick = hop_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hop_q <= '{tick: '0, pos: POS_MID, dir: HOP_UP};
        end else begin
            hop_q <= hop_d;
        end
    end

    assign pos_o = hop_q.pos;
endmodule

// File: rtl/pwm_ct_mode.sv
module pwm_ct_mode
    import pwm_ct_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample_en,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        fb_hi,
    input  logic        fb_lo,
    output line_range_e range_o,
    output logic        run_o
);
    typedef struct packed {
        line_range_e rng;
        logic        run;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (sample_en) begin
            if (line_hi)      mode_d.rng = RNG_HIGH_LINE;
            else if (line_lo) mode_d.rng = RNG_LOW_LINE;
        end
        if (fb_hi)      mode_d.run = 1'b1;
        else if (fb_lo) mode_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{rng: RNG_LOW_LINE, run: 1'b1};
        end else begin
            mode_q <= mode_d;
        end
    end

    assign range_o = mode_q.rng;
    assign run_o   = mode_q.run;
endmodule

// File: rtl/pwm_cycle_timer.sv
module pwm_cycle_timer
    import pwm_ct_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int FAST_PER     = 714,
    parameter int SLOW_PER     = 1176,
    parameter int FAST_STEP    = 2,
    parameter int SLOW_STEP    = 10,
    parameter int HOP_STEPS    = 10,
    parameter int HOP_DWELL    = 6350,
    parameter int DUTY_NUM     = 701,
    parameter int DUTY_SHIFT   = 10,
    parameter int BLANK_TICKS  = 15,
    parameter int MIN_ON_TICKS = 55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vloop_trip_i,
    input  logic             iloop_trip_i,
    input  logic             ilim_trip_i,
    input  logic             fb_high_i,
    input  logic             fb_low_i,
    input  logic             line_hi_i,
    input  logic             line_lo_i,
    output logic             gate_o,
    output logic             cycle_start_o,
    output logic             mid_on_o,
    output logic [CNT_W-1:0] ton_half_o
);
    localparam int POS_W  = $clog2(2 * HOP_STEPS + 1);
    localparam int PROD_W = CNT_W + DUTY_SHIFT;
    localparam logic [CNT_W-1:0]  FAST_BOT = CNT_W'(FAST_PER - HOP_STEPS * FAST_STEP);
    localparam logic [CNT_W-1:0]  SLOW_BOT = CNT_W'(SLOW_PER - HOP_STEPS * SLOW_STEP);
    localparam logic [CNT_W-1:0]  FAST_INC = CNT_W'(FAST_STEP);
    localparam logic [CNT_W-1:0]  SLOW_INC = CNT_W'(SLOW_STEP);
    localparam logic [CNT_W-1:0]  BLANK_C  = CNT_W'(BLANK_TICKS);
    localparam logic [CNT_W-1:0]  MINON_C  = CNT_W'(MIN_ON_TICKS);
    localparam logic [CNT_W-1:0]  RST_PER  = CNT_W'(FAST_PER);
    localparam logic [PROD_W-1:0] DUTY_C   = PROD_W'(DUTY_NUM);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] max_on;
        logic [CNT_W-1:0] on;
        logic [CNT_W-1:0] half;
        logic             gate;
        logic             start;
        logic             mid;
    } tmr_t;

    tmr_t        tmr_d, tmr_q;
    logic [POS_W-1:0] hop_pos;
    line_range_e rng;
    logic        run;
    logic [CNT_W-1:0]  per_next;
    logic [PROD_W-1:0] duty_prod;
    logic [CNT_W-1:0]  max_on_next;
    logic        cycle_end;
    logic        stop_now;
    logic [CNT_W-1:0] cur_max_on;

    pwm_ct_hop #(
        .HOP_STEPS(HOP_STEPS),
        .HOP_DWELL(HOP_DWELL)
    ) u_hop (
        .clk  (clk),
        .rst_n(rst_n),
        .pos_o(hop_pos)
    );

    pwm_ct_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(tmr_q.gate),
        .line_hi  (line_hi_i),
        .line_lo  (line_lo_i),
        .fb_hi    (fb_high_i),
        .fb_lo    (fb_low_i),
        .range_o  (rng),
        .run_o    (run)
    );

    // Period of the coming cycle: range base at the bottom of the sweep plus hop steps.
    always_comb begin
        if (rng == RNG_HIGH_LINE) per_next = SLOW_BOT + CNT_W'(hop_pos) * SLOW_INC;
        else                      per_next = FAST_BOT + CNT_W'(hop_pos) * FAST_INC;
        duty_prod   = PROD_W'(per_next) * DUTY_C;
        max_on_next = duty_prod[PROD_W-1:DUTY_SHIFT];
    end

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.start = 1'b0;
        tmr_d.mid   = 1'b0;
        cycle_end   = (tmr_q.cnt == tmr_q.per - 1'b1);
        stop_now    = (tmr_q.on >= tmr_q.max_on)
                    || ((vloop_trip_i || iloop_trip_i) && (tmr_q.on >= MINON_C))
                    || (ilim_trip_i && (tmr_q.on > BLANK_C));
        if (cycle_end) begin
            tmr_d.cnt    = '0;
            tmr_d.per    = per_next;
            tmr_d.max_on = max_on_next;
            tmr_d.gate   = run;
            tmr_d.start  = run;
            tmr_d.on     = run ? CNT_W'(1) : '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            if (tmr_q.gate) begin
                if (stop_now) begin
                    tmr_d.gate = 1'b0;
                    tmr_d.mid  = 1'b1;
                    tmr_d.half = tmr_q.on >> 1;
                end else begin
                    tmr_d.on = tmr_q.on + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: '0, per: RST_PER, max_on: '0, on: '0, half: '0,
                       gate: 1'b0, start: 1'b0, mid: 1'b0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign gate_o        = tmr_q.gate;
    assign cycle_start_o = tmr_q.start;
    assign mid_on_o      = tmr_q.mid;
    assign ton_half_o    = tmr_q.half;
    assign cur_max_on    = tmr_q.max_on;
endmodule

// File: rtl/pwm_ct_chk.sv
module pwm_ct_chk #(
    parameter int CNT_W        = 16,
    parameter int BLANK_TICKS  = 15,
    parameter int MIN_ON_TICKS = 55
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate,
    input logic             start,
    input logic             mid,
    input logic             ilim,
    input logic [CNT_W-1:0] max_on
);
    localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK_TICKS);
    localparam logic [CNT_W-1:0] MINON_C = CNT_W'(MIN_ON_TICKS);

    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] hi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= gate ? hi_q + 1'b1 : '0;
    end
    assign hi_n = hi_q + 1'b1;

    // R8
    start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> start);
    // R8
    mid_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> mid);
    // R2
    duty_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (hi_n <= max_on));
    // R4
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && hi_n <= BLANK_C) |=> gate);
    // R3
    min_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && hi_n < MINON_C && !(ilim && hi_n > BLANK_C)) |=> gate);
endmodule

bind pwm_cycle_timer pwm_ct_chk #(
    .CNT_W       (CNT_W),
    .BLANK_TICKS (BLANK_TICKS),
    .MIN_ON_TICKS(MIN_ON_TICKS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate_o),
    .start (cycle_start_o),
    .mid   (mid_on_o),
    .ilim  (ilim_trip_i),
    .max_on(cur_max_on)
);

// File: tb/tb_pwm_cycle_timer.sv
module tb_pwm_cycle_timer;
    localparam int CW    = 16;
    localparam int FPER  = 40;
    localparam int SPER  = 64;
    localparam int FSTEP = 1;
    localparam int SSTEP = 3;
    localparam int HS    = 3;
    localparam int DWELL = 100;
    localparam int DNUM  = 701;
    localparam int DSH   = 10;
    localparam int BLANK = 3;
    localparam int MINON = 6;
    localparam int CAP   = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vloop = 1'b0, iloop = 1'b0, ilim = 1'b0;
    logic fb_hi = 1'b0, fb_lo = 1'b0, line_hi = 1'b0, line_lo = 1'b0;
    logic gate, cstart, mid;
    logic [CW-1:0] half;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_cycle_timer #(
        .CNT_W(CW), .FAST_PER(FPER), .SLOW_PER(SPER), .FAST_STEP(FSTEP),
        .SLOW_STEP(SSTEP), .HOP_STEPS(HS), .HOP_DWELL(DWELL), .DUTY_NUM(DNUM),
        .DUTY_SHIFT(DSH), .BLANK_TICKS(BLANK), .MIN_ON_TICKS(MINON)
    ) dut (
        .clk(clk), .rst_n(rst_n), .vloop_trip_i(vloop), .iloop_trip_i(iloop),
        .ilim_trip_i(ilim), .fb_high_i(fb_hi), .fb_low_i(fb_lo),
        .line_hi_i(line_hi), .line_lo_i(line_lo), .gate_o(gate),
        .cycle_start_o(cstart), .mid_on_o(mid), .ton_half_o(half)
    );

    function automatic int ceil_on(input int p);
        return (p * DNUM) >> DSH;
    endfunction

    function automatic bit in_range(input int p, input int base, input int step);
        int lo;
        lo = base - HS * step;
        return (p >= lo) && (p <= base + HS * step) && (((p - lo) % step) == 0);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entered at a negedge showing cycle_start; returns at the next one (or at CAP ticks).
    // mode: 0 none, 1 vloop held from k, 2 iloop held from k, 3 ilim held from k,
    //       4 ilim single tick at k, 5 line_hi during off time only, 6 fb_lo at tick 2 + vloop from k
    task automatic run_cycle(input int mode, input int k, output int len, output int per,
                             output int mids, output int hv, output bit restarted);
        len = 0; per = 0; mids = 0; hv = -1;
        do begin
            if (gate) begin
                len++;
                vloop = (mode == 1 || mode == 6) && (len >= k);
                iloop = (mode == 2) && (len >= k);
                ilim  = ((mode == 3) && (len >= k)) || ((mode == 4) && (len == k));
                fb_lo = (mode == 6) && (len == 2);
            end else begin
                vloop = 1'b0; iloop = 1'b0; ilim = 1'b0; fb_lo = 1'b0;
                if (mode == 5) line_hi = 1'b1;
            end
            if (mid) begin
                mids++;
                hv = int'(half);
            end
            per++;
            @(negedge clk);
            if (mode == 5 && cstart) line_hi = 1'b0;
        end while (!cstart && per < CAP);
        restarted = cstart;
    endtask

    task automatic plain_cycle(input int base, input int step, input string req,
                               output int per);
        int len, mids, hv;
        bit rs;
        run_cycle(0, 0, len, per, mids, hv, rs);
        check(in_range(per, base, step), req, per, base);
        check(len == ceil_on(per), "R2 duty ceiling", len, ceil_on(per));
        check(mids == 1 && hv == len / 2, "R8 mid strobe half", hv, len / 2);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, len, per, mids, hv, pmin, pmax, prev, p;
        bit rs;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(gate == 1'b0 && cstart == 1'b0 && mid == 1'b0, "R1 reset outputs", gate, 0);
        rst_n = 1'b1;
        t = 0;
        do begin @(negedge clk); t++; end while (!cstart && t < CAP);
        check(t == FPER, "R1 first turn-on delay", t, FPER);
        check(gate == 1'b1, "R8 start coincides with gate", gate, 1);

        // R2 / R7 / R8: free running, low-line range, full hop sweeps
        pmin = 1000; pmax = 0; prev = -1;
        for (int i = 0; i < 40; i++) begin
            plain_cycle(FPER, FSTEP, "R7 fast period set", p);
            if (prev >= 0) check((p - prev <= FSTEP) && (prev - p <= FSTEP), "R7 hop slew", p, prev);
            prev = p;
            if (p < pmin) pmin = p;
            if (p > pmax) pmax = p;
        end
        check(pmin == FPER - HS * FSTEP, "R7 fast sweep bottom", pmin, FPER - HS * FSTEP);
        check(pmax == FPER + HS * FSTEP, "R7 fast sweep top", pmax, FPER + HS * FSTEP);

        // R3 loop trips, both sources, every trip tick
        for (int k = 1; k <= 20; k++) begin
            run_cycle(1, k, len, per, mids, hv, rs);
            check(len == imax(k, MINON), "R3 voltage trip length", len, imax(k, MINON));
            run_cycle(2, k, len, per, mids, hv, rs);
            check(len == imax(k, MINON), "R3 current-loop trip length", len, imax(k, MINON));
            check(mids == 1 && hv == len / 2, "R8 half after trip", hv, len / 2);
        end

        // R4 current limit: held from k, and single ticks inside/after blanking
        for (int k = 1; k <= 20; k++) begin
            run_cycle(3, k, len, per, mids, hv, rs);
            check(len == imax(k, BLANK + 1), "R4 limit length", len, imax(k, BLANK + 1));
        end
        for (int k = 1; k <= BLANK; k++) begin
            run_cycle(4, k, len, per, mids, hv, rs);
            check(len == ceil_on(per), "R4 blanked glitch ignored", len, ceil_on(per));
        end
        run_cycle(4, BLANK + 1, len, per, mids, hv, rs);
        check(len == BLANK + 1, "R4 first unblanked tick", len, BLANK + 1);

        // R6 burst stop and restart
        run_cycle(6, 12, len, per, mids, hv, rs);
        check(len == 12, "R6 current pulse not shortened", len, 12);
        check(rs == 1'b0, "R6 no restart while stopped", rs, 0);
        fb_hi = 1'b1;
        @(negedge clk);
        fb_hi = 1'b0;
        t = 0;
        do begin @(negedge clk); t++; end while (!cstart && t < CAP);
        check(t <= FPER + HS * FSTEP, "R6 restart at next boundary", t, FPER + HS * FSTEP);

        // R5 line range selection
        run_cycle(5, 0, len, per, mids, hv, rs);
        plain_cycle(FPER, FSTEP, "R5 off-time flag ignored", p);
        line_hi = 1'b1;
        plain_cycle(FPER, FSTEP, "R5 current cycle keeps period", p);
        plain_cycle(SPER, SSTEP, "R5 high line selects long period", p);
        line_hi = 1'b0;
        pmin = 1000; pmax = 0;
        for (int i = 0; i < 30; i++) begin
            plain_cycle(SPER, SSTEP, "R5 hold between thresholds", p);
            if (p < pmin) pmin = p;
            if (p > pmax) pmax = p;
        end
        check(pmin == SPER - HS * SSTEP, "R7 slow sweep bottom", pmin, SPER - HS * SSTEP);
        check(pmax == SPER + HS * SSTEP, "R7 slow sweep top", pmax, SPER + HS * SSTEP);
        line_lo = 1'b1;
        plain_cycle(SPER, SSTEP, "R5 current cycle keeps long period", p);
        plain_cycle(FPER, FSTEP, "R5 low line selects short period", p);
        line_lo = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule